// File: doc/BRIEF.md
# Preloadable 16-bit Timer/Event Counter

This block is a 16-bit up-counter that a processor reaches through three byte-wide registers: a high-byte port, a low-byte port and a control port. The counter advances from its present value to FFFFh. On the next count it reloads from a 16-bit preload register and raises a request flag. The flag stays high until an external clear pulse removes it.

Each 16-bit value passes through an 8-bit low-byte buffer, so it moves as one unit. A write to the low-byte port only fills the buffer. A write to the high-byte port then moves the new high byte together with the buffered low byte into the preload register. A read of the high-byte port returns the live high byte and, in the same cycle, captures the live low byte into the buffer. A following read of the low-byte port returns that captured byte.

The counter has three counting modes:
- **Timer:** it counts the system clock divided by four.
- **Event:** it counts a chosen edge of an external pin.
- **Pulse-width:** it times one level period of the pin, then turns its own run bit off.

Top module: `preload_counter16`

## Requirements
- R1: A write to the low-byte port (regSel=0) changes only the low-byte buffer. A write to the high-byte port (regSel=1) loads {wrData, buffer} into the preload register. If run is 0, the same write also loads the counter.
- R2: A read of the high-byte port returns counter bits 15:8 and captures counter bits 7:0 into the buffer at that clock edge. A read of the low-byte port returns the buffer, even if the live counter has moved since.
- R3: A count while the counter is FFFFh loads the counter from the preload register and sets irqFlag at the same clock edge.
- R4: While run is 1, a preload write leaves the counter unchanged. The new preload value is used at the next overflow.
- R5: Control port (regSel=2) layout: bit 3 selects the edge (0 rising, 1 falling), bit 4 is run, and bits 7:6 select the mode (01 event, 10 timer, 11 pulse-width). Bits 2:0 and 5 read as 0. regSel=3 reads as 00h. rdData is 00h when rdEn is low.
- R6: In timer mode with run=1, the counter advances once every 4 clock cycles. The first increment comes 4 edges after run is set.
- R7: In event mode with run=1, the counter advances once per selected edge of extPin. The pin passes through a two-flop synchronizer, and the increment lands on the third rising clock edge after the pin changes. The other edge is ignored.
- R8: In pulse-width mode, the selected edge of extPin starts counting at the timer rate, and the return to the original level stops it. At the stop, run clears itself, and later pulses are not measured.
- R9: In a cycle with a high-byte read, any count that would occur in that cycle is dropped.
- R10: irqFlag stays high until a flagClr pulse. If an overflow and flagClr happen in the same cycle, the overflow wins.
- R11: After reset, the counter, the preload register, the buffer, the control register and irqFlag are all zero.
- R12: Mode 00 does not count, even with run=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regSel | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 none |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| extPin | input | 1 | External event / pulse input (asynchronous) |
| flagClr | input | 1 | Clears irqFlag |
| irqFlag | output | 1 | Overflow request flag (level) |

## Verification
The hardest case to reach is a high-byte read that lands exactly in the cycle where a count is due. Only then can the dropped count be seen. The bench sets up this case in event mode. It changes the pin at a known falling clock edge, counts the two synchronizer stages, and asserts the high-byte read during the third cycle. It then reads back the unchanged count. Overflow cases are set up by preloading values just below FFFFh and letting the timer run for an exact number of prescaled ticks.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_NONE = 2'b11
  } regSel_t;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } cntMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic inc;       // advance the counter this cycle
    logic loadPre;   // high-byte write: fill preload register
    logic loadCnt;   // high-byte write while stopped: fill counter too
    logic bufWr;     // low-byte write into buffer
    logic latchLow;  // high-byte read: capture live low byte
  } cntStrobe_t;

endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
#(
  parameter int PRE_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] regSel,
  input  logic [1:0] newMode,
  input  logic       newRun,
  input  logic       newEdge,
  input  logic       extPin,
  output cntStrobe_t st,
  output logic [1:0] modeOut,
  output logic       runOut,
  output logic       edgeOut
);

  cntMode_t          mode;
  logic              runEn;
  logic              edgeSel;
  logic              measuring;
  logic [PRE_W-1:0]  preCnt;
  logic [SYNC_N-1:0] syncQ;
  logic              pinPrev;
  logic              pinS;

  // input synchronizer chain
  generate
    for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= extPin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  assign pinS = syncQ[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinS;

  logic riseDet, fallDet, actEdge, retEdge;
  logic ctrlWr, hiRd;
  logic pwStart, pwStop, preRun, preTick, rawTick;

  always_comb begin
    riseDet = pinS & ~pinPrev;
    fallDet = ~pinS & pinPrev;
    actEdge = edgeSel ? fallDet : riseDet;
    retEdge = edgeSel ? riseDet : fallDet;
    ctrlWr  = wrEn && (regSel == SEL_CTRL);
    hiRd    = rdEn && (regSel == SEL_HIGH);
    pwStart = runEn && (mode == MODE_PULSE) && !measuring && actEdge;
    pwStop  = measuring && retEdge;
    preRun  = ((mode == MODE_TIMER) && runEn) || measuring;
    preTick = preRun && (preCnt == {PRE_W{1'b1}});
    unique case (mode)
      MODE_EVENT: rawTick = runEn && actEdge;
      MODE_TIMER: rawTick = preTick;
      MODE_PULSE: rawTick = measuring && preTick;
      default:    rawTick = 1'b0;
    endcase
  end

  // prescaler
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        preCnt <= '0;
    else if (!preRun) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;

  // control register and pulse-width state
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      mode      <= MODE_OFF;
      runEn     <= 1'b0;
      edgeSel   <= 1'b0;
      measuring <= 1'b0;
    end else if (ctrlWr) begin
      mode      <= cntMode_t'(newMode);
      runEn     <= newRun;
      edgeSel   <= newEdge;
      measuring <= 1'b0;
    end else if (pwStop) begin
      measuring <= 1'b0;
      runEn     <= 1'b0;
    end else if (pwStart) begin
      measuring <= 1'b1;
    end

  always_comb begin
    st.inc      = rawTick && !hiRd;
    st.loadPre  = wrEn && (regSel == SEL_HIGH);
    st.loadCnt  = wrEn && (regSel == SEL_HIGH) && !runEn;
    st.bufWr    = wrEn && (regSel == SEL_LOW);
    st.latchLow = hiRd;
  end

  assign modeOut = mode;
  assign runOut  = runEn;
  assign edgeOut = edgeSel;

  assert_selfclear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (measuring && retEdge && !ctrlWr) |=> !runEn);

  assert_event_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_EVENT && !actEdge) |-> !st.inc);

  assert_timer_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.inc && mode == MODE_TIMER && !ctrlWr) |=> !st.inc);

  assert_off_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> !st.inc);

endmodule

// File: rtl/pcnt_datapath.sv
module pcnt_datapath
  import pcnt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        st,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  output logic [BYTE_W-1:0] cntHigh,
  output logic [BYTE_W-1:0] bufOut,
  output logic              irqFlag
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  preload;
  logic [BYTE_W-1:0] lowBuf;
  logic              overflow;

  assign overflow = st.inc && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          cnt <= '0;
    else if (st.loadCnt) cnt <= {wrData, lowBuf};
    else if (overflow)  cnt <= preload;
    else if (st.inc)    cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           preload <= '0;
    else if (st.loadPre) preload <= {wrData, lowBuf};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            lowBuf <= '0;
    else if (st.bufWr)    lowBuf <= wrData;
    else if (st.latchLow) lowBuf <= cnt[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        irqFlag <= 1'b0;
    else if (overflow) irqFlag <= 1'b1;
    else if (flagClr) irqFlag <= 1'b0;

  assign cntHigh = cnt[CNT_W-1:BYTE_W];
  assign bufOut  = lowBuf;

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.inc && !st.loadCnt && cnt == {CNT_W{1'b1}}) |=> (cnt == $past(preload) && irqFlag));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!st.inc && !st.loadCnt) |=> $stable(cnt));

  assert_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.latchLow && !st.loadCnt) |=> $stable(cnt));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);

endmodule

// File: rtl/preload_counter16.sv
module preload_counter16
  import pcnt_pkg::*;
#(
  parameter int PRE_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       extPin,
  input  logic       flagClr,
  output logic       irqFlag
);

  localparam int BYTE_W = 8;

  cntStrobe_t        st;
  logic [1:0]        modeOut;
  logic              runOut;
  logic              edgeOut;
  logic [BYTE_W-1:0] cntHigh;
  logic [BYTE_W-1:0] bufOut;

  pcnt_ctrl #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .newMode(wrData[7:6]), .newRun(wrData[4]), .newEdge(wrData[3]),
    .extPin(extPin), .st(st), .modeOut(modeOut), .runOut(runOut), .edgeOut(edgeOut)
  );

  pcnt_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .flagClr(flagClr),
    .cntHigh(cntHigh), .bufOut(bufOut), .irqFlag(irqFlag)
  );

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (regSel)
        SEL_LOW:  rdData = bufOut;
        SEL_HIGH: rdData = cntHigh;
        SEL_CTRL: rdData = {modeOut, 1'b0, runOut, edgeOut, 3'b000};
        default:  rdData = '0;
      endcase
    end
  end

endmodule

// File: tb/sim_preload_counter16.sv
module sim_preload_counter16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] regSel = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       extPin = 1'b0;
  logic       flagClr = 1'b0;
  logic       irqFlag;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  preload_counter16 u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .extPin(extPin), .flagClr(flagClr),
    .irqFlag(irqFlag)
  );

  typedef struct packed {
    logic [15:0] pre;
    logic [7:0]  ticks;
    logic [15:0] expCnt;
    logic        expFlag;
  } vec_t;

  // timer-mode vectors: preload, prescaled ticks, expected count, flag
  localparam vec_t VECS [0:5] = '{
    '{16'h0000, 8'd5, 16'h0005, 1'b0},
    '{16'h12FF, 8'd2, 16'h1301, 1'b0},
    '{16'hFFFE, 8'd3, 16'hFFFF, 1'b1},
    '{16'hFFFF, 8'd1, 16'hFFFF, 1'b1},
    '{16'hFFFD, 8'd4, 16'hFFFE, 1'b1},
    '{16'hA5C3, 8'd7, 16'hA5CA, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wrNow(input logic [1:0] sel, input logic [7:0] d);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [7:0] v);
    rdEn = 1'b1; regSel = sel;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdCount(output logic [15:0] v);
    logic [7:0] h, l;
    rdReg(2'd1, h);
    rdReg(2'd2 - 2'd2, l);
    v = {h, l};
  endtask

  task automatic loadPre(input logic [15:0] p);
    wrNow(2'd0, p[7:0]);
    wrNow(2'd1, p[15:8]);
  endtask

  task automatic clrFlag();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic waitUntil(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic pinHold(input logic v, input int n);
    extPin = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    nBad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c;
    int t0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    rdReg(2'd1, b); chk("R11 high", b, 8'h00);
    rdReg(2'd0, b); chk("R11 low", b, 8'h00);
    rdReg(2'd2, b); chk("R11 ctrl", b, 8'h00);
    chk("R11 flag", irqFlag, 1'b0);

    // R5 control layout and unused selects
    wrNow(2'd2, 8'hFF);
    rdReg(2'd2, b); chk("R5 ctrl readback", b, 8'hD8);
    rdReg(2'd3, b); chk("R5 sel3", b, 8'h00);
    chk("R5 idle rdData", rdData, 8'h00);
    wrNow(2'd2, 8'h00);
    rdReg(2'd2, b); chk("R5 ctrl cleared", b, 8'h00);

    // R1 buffered preload, stopped -> also counter
    loadPre(16'h1234);
    rdCount(c); chk("R1 stopped load", c, 16'h1234);
    wrNow(2'd0, 8'h99);
    rdReg(2'd1, b); chk("R1 low write no effect high", b, 8'h12);
    rdReg(2'd0, b); chk("R1 low write no effect low", b, 8'h34);

    // R6 / R3 vector table in timer mode
    for (int i = 0; i < 6; i++) begin
      loadPre(VECS[i].pre);
      clrFlag();
      wrNow(2'd2, 8'h90);
      t0 = cyc;
      waitUntil(t0 + 4 * int'(VECS[i].ticks) - 1);
      wrNow(2'd2, 8'h80);
      rdCount(c); chk($sformatf("R6 R3 vec%0d count", i), c, VECS[i].expCnt);
      chk($sformatf("R3 vec%0d flag", i), irqFlag, VECS[i].expFlag);
    end

    // R4 preload write while running
    loadPre(16'hFFF0);
    clrFlag();
    wrNow(2'd2, 8'h90);
    t0 = cyc;
    loadPre(16'h1234);
    waitUntil(t0 + 67);
    wrNow(2'd2, 8'h80);
    rdCount(c); chk("R4 reload uses new preload", c, 16'h1235);
    chk("R3 flag after running reload", irqFlag, 1'b1);

    // R10 flag holds, then clears
    repeat (5) @(negedge clk);
    chk("R10 flag held", irqFlag, 1'b1);
    clrFlag();
    chk("R10 flag cleared", irqFlag, 1'b0);

    // R12 mode 00 with run
    wrNow(2'd2, 8'h10);
    repeat (20) @(negedge clk);
    wrNow(2'd2, 8'h00);
    rdCount(c); chk("R12 off mode", c, 16'h1235);

    // R7 event mode
    loadPre(16'h0010);
    wrNow(2'd2, 8'h50);
    for (int k = 0; k < 3; k++) begin
      pinHold(1'b1, 4);
      pinHold(1'b0, 4);
    end
    rdCount(c); chk("R7 rising events", c, 16'h0013);
    wrNow(2'd2, 8'h58);
    pinHold(1'b1, 4);
    rdCount(c); chk("R7 rising ignored", c, 16'h0013);
    pinHold(1'b0, 4);
    rdCount(c); chk("R7 falling counted", c, 16'h0014);

    // R2 buffer holds captured low byte
    rdReg(2'd1, b); chk("R2 high", b, 8'h00);
    pinHold(1'b1, 4);
    pinHold(1'b0, 4);
    rdReg(2'd0, b); chk("R2 buffered low", b, 8'h14);
    rdCount(c); chk("R2 fresh count", c, 16'h0015);

    // R9 high read drops a count in its cycle
    pinHold(1'b1, 4);
    extPin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rdEn = 1'b1; regSel = 2'd1;
    @(negedge clk);
    rdEn = 1'b0;
    repeat (3) @(negedge clk);
    rdCount(c); chk("R9 blocked count", c, 16'h0015);
    pinHold(1'b1, 4);
    pinHold(1'b0, 4);
    rdCount(c); chk("R9 next count", c, 16'h0016);

    // R8 pulse-width one-shot
    wrNow(2'd2, 8'h00);
    loadPre(16'h0000);
    wrNow(2'd2, 8'hD0);
    pinHold(1'b0, 4);
    pinHold(1'b1, 42);
    pinHold(1'b0, 6);
    rdCount(c); chk("R8 width", c, 16'h000A);
    rdReg(2'd2, b); chk("R8 run self-cleared", b, 8'hC0);
    pinHold(1'b1, 20);
    pinHold(1'b0, 6);
    rdCount(c); chk("R8 no second measure", c, 16'h000A);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule